// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block puts a small word-organised storage array behind the multi-cycle write protocol of a NOR-style flash. A host writes bus cycles (address, data, one-cycle strobe). A decoder walks them through an unlock prefix and a command code. It then launches one of three embedded operations: word program, sector erase or chip erase. Each operation is timed internally by a cycle counter. While an operation runs, `busy` is high and every host write is dropped.

Flash rules apply to the stored bits. Erase drives every bit of a word to 1. Program can only clear bits, so the new word is the old word ANDed with the written data. A per-sector protect input, sampled when an operation starts, has two effects. A chip erase leaves protected sectors untouched. A sector erase aimed at a protected sector erases nothing and finishes after a short fixed time.

The write port is a plain strobe with no back-pressure. The host must poll `busy` and issue the next command only after `busy` is low. The read port is combinational: `rd_data` shows the word selected by `rd_addr` in the same cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy` is low and the decoder waits for the first unlock cycle.
- R2: Word program is four writes: 0xAA to address 0x555, then 0x55 to 0x2AA, then 0xA0 to 0x555, then the target address with its data. Afterwards the target word holds its old value ANDed with the data.
- R3: Sector erase is six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address in the target sector. The sector is selected by word-address bits [4:3], with 8 words per sector. Every word of that sector becomes 0xFFFF, and words of other sectors keep their value.
- R4: Chip erase is the same six-write sequence ending with 0x10@0x555. It sets every word of every unprotected sector to 0xFFFF, and protected sectors are left unchanged (`lock[s]`=1 protects sector s).
- R5: A sector erase of a protected sector changes no word, and `busy` stays high for exactly LOCK_CYC cycles.
- R6: Writes that arrive while `busy` is high change no word and do not advance the decoder. A full command written during `busy` therefore has no effect, not even once `busy` falls.
- R7: Command codes are compared only on `wdata[7:0]`; `wdata[15:8]` is ignored in command cycles.
- R8: A write that does not match the address and code expected next returns the decoder to its idle state without touching the array. A following data-only or partial sequence is then not acted on.
- R9: Pulling `rst_n` low during an operation ends it at once (`busy` low). Words other than the one being programmed keep their contents, and a new command afterwards works normally.
- R10: `busy` rises in the cycle after the final write of a command and stays high for exactly PROG_CYC, SEC_CYC or CHIP_CYC cycles, matching the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; aborts any running operation |
| wr_en | input | 1 | One-cycle host write strobe |
| addr | input | 11 | Write address; command cycles decode all 11 bits, array selects use bits [4:0] |
| wdata | input | 16 | Write data; low byte carries command codes |
| lock | input | 4 | Per-sector protect, sampled at operation start |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 16 | Word stored at `rd_addr` |
| busy | output | 1 | High while an embedded operation runs |

## Verification
The checks assume that `wr_en` is a single-cycle pulse with `addr` and `wdata` valid in the same cycle. They also assume that `rd_addr` is held steady whenever stored data is compared across cycles, and that a reset pulse lasts at least one clock edge. The stimulus keeps to these rules. Every write is a strobe raised for one cycle and dropped for the next, with inputs changed only on the falling clock edge. The read address is changed only once `busy` has fallen. The one reset pulse during an operation spans a full cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] SEQ_ADDR_A = 11'h555;
  localparam logic [CMD_AW-1:0] SEQ_ADDR_B = 11'h2AA;
  localparam logic [7:0] CODE_UNLK1 = 8'hAA;
  localparam logic [7:0] CODE_UNLK2 = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERASE = 8'h80;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_SECT  = 8'h30;

  typedef enum logic [1:0] {
    OPK_PROG = 2'd0,
    OPK_SECT = 2'd1,
    OPK_CHIP = 2'd2,
    OPK_NONE = 2'd3
  } op_kind_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PDATA, SQ_E0, SQ_E1, SQ_E2
  } seq_state_t;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMD_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              busy,
  output logic              start,
  output op_kind_t          kind,
  output logic              idle
);
  seq_state_t state, nxt;

  function automatic logic hit(input logic [CMD_AW-1:0] a, input logic [7:0] c,
                               input logic [CMD_AW-1:0] ea, input logic [7:0] ec);
    return (a == ea) && (c == ec);
  endfunction

  logic [7:0] code;
  assign code = wdata[7:0];

  always_comb begin
    nxt   = state;
    start = 1'b0;
    kind  = OPK_NONE;
    if (wr_en && !busy) begin
      nxt = SQ_IDLE;
      unique case (state)
        SQ_IDLE:  if (hit(addr, code, SEQ_ADDR_A, CODE_UNLK1)) nxt = SQ_U1;
        SQ_U1:    if (hit(addr, code, SEQ_ADDR_B, CODE_UNLK2)) nxt = SQ_U2;
        SQ_U2: begin
          if (hit(addr, code, SEQ_ADDR_A, CODE_PROG))       nxt = SQ_PDATA;
          else if (hit(addr, code, SEQ_ADDR_A, CODE_ERASE)) nxt = SQ_E0;
        end
        SQ_PDATA: begin
          start = 1'b1;
          kind  = OPK_PROG;
        end
        SQ_E0:    if (hit(addr, code, SEQ_ADDR_A, CODE_UNLK1)) nxt = SQ_E1;
        SQ_E1:    if (hit(addr, code, SEQ_ADDR_B, CODE_UNLK2)) nxt = SQ_E2;
        SQ_E2: begin
          if (hit(addr, code, SEQ_ADDR_A, CODE_CHIP)) begin
            start = 1'b1;
            kind  = OPK_CHIP;
          end else if (code == CODE_SECT) begin
            start = 1'b1;
            kind  = OPK_SECT;
          end
        end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SQ_IDLE;
    else if (busy) state <= SQ_IDLE;
    else           state <= nxt;
  end

  assign idle = (state == SQ_IDLE);
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= load;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_cmd_pkg::*;
#(
  parameter int DW      = 16,
  parameter int SECTORS = 4,
  parameter int WPS     = 8,
  localparam int WORDS  = SECTORS * WPS,
  localparam int IW     = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               prog_begin,
  input  logic [IW-1:0]      begin_idx,
  input  logic [DW-1:0]      begin_data,
  input  logic               commit,
  input  op_kind_t           commit_kind,
  input  logic [IW-1:0]      commit_idx,
  input  logic [DW-1:0]      commit_data,
  input  logic [SECTORS-1:0] erase_mask,
  input  logic [IW-1:0]      rd_idx,
  output logic [DW-1:0]      rd_data
);
  localparam logic [DW-1:0] LOW_HALF = {{(DW-DW/2){1'b0}}, {(DW/2){1'b1}}};

  logic [DW-1:0] mem [WORDS];

  assign rd_data = mem[rd_idx];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (commit && (commit_kind == OPK_SECT || commit_kind == OPK_CHIP)) begin
        if (erase_mask[w / WPS]) mem[w] <= '1;
      end else if (commit && commit_kind == OPK_PROG && commit_idx == IW'(w)) begin
        mem[w] <= mem[w] & commit_data;
      end else if (prog_begin && begin_idx == IW'(w)) begin
        // upper half is pulled low first; an abort leaves a half-written word
        mem[w] <= mem[w] & (begin_data | LOW_HALF);
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int DW        = 16,
  parameter int SECTORS   = 4,
  parameter int WPS       = 8,
  parameter int PROG_CYC  = 12,
  parameter int SEC_CYC   = 16,
  parameter int CHIP_CYC  = 20,
  parameter int LOCK_CYC  = 3,
  localparam int WORDS    = SECTORS * WPS,
  localparam int IW       = $clog2(WORDS),
  localparam int SW       = $clog2(WPS),
  localparam int MAX_A    = (PROG_CYC > SEC_CYC) ? PROG_CYC : SEC_CYC,
  localparam int MAX_B    = (CHIP_CYC > LOCK_CYC) ? CHIP_CYC : LOCK_CYC,
  localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int CW       = $clog2(MAX_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CMD_AW-1:0]  addr,
  input  logic [DW-1:0]      wdata,
  input  logic [SECTORS-1:0] lock,
  input  logic [IW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic               busy
);
  logic          start, done, dec_idle;
  op_kind_t      start_kind, op_kind;
  logic [IW-1:0] op_idx;
  logic [DW-1:0] op_data;
  logic [SECTORS-1:0] op_mask, new_mask;
  logic [CW-1:0] load;
  logic [IW-1:0] tgt_idx;
  logic          tgt_locked;

  assign tgt_idx    = addr[IW-1:0];
  assign tgt_locked = lock[tgt_idx[IW-1:SW]];

  flash_cmd_decode #(.DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy(busy), .start(start), .kind(start_kind), .idle(dec_idle)
  );

  always_comb begin
    new_mask = '0;
    load     = CW'(PROG_CYC - 1);
    unique case (start_kind)
      OPK_SECT: begin
        if (tgt_locked) load = CW'(LOCK_CYC - 1);
        else begin
          load = CW'(SEC_CYC - 1);
          new_mask[tgt_idx[IW-1:SW]] = 1'b1;
        end
      end
      OPK_CHIP: begin
        load     = CW'(CHIP_CYC - 1);
        new_mask = ~lock;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_kind <= OPK_NONE;
      op_idx  <= '0;
      op_data <= '1;
      op_mask <= '0;
    end else if (start && !busy) begin
      op_kind <= start_kind;
      op_idx  <= tgt_idx;
      op_data <= wdata;
      op_mask <= new_mask;
    end
  end

  flash_op_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load),
    .busy(busy), .done(done)
  );

  flash_store #(.DW(DW), .SECTORS(SECTORS), .WPS(WPS)) u_mem (
    .clk(clk),
    .prog_begin(start && !busy && start_kind == OPK_PROG),
    .begin_idx(tgt_idx), .begin_data(wdata),
    .commit(done), .commit_kind(op_kind), .commit_idx(op_idx),
    .commit_data(op_data), .erase_mask(op_mask),
    .rd_idx(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int DW       = 16,
  parameter int IW       = 5,
  parameter int PROG_CYC = 12,
  parameter int SEC_CYC  = 16,
  parameter int CHIP_CYC = 20,
  parameter int LOCK_CYC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          busy,
  input logic          dec_idle,
  input logic [IW-1:0] rd_addr,
  input logic [DW-1:0] rd_data
);
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 8'd1;
    else           run_len <= '0;
  end

  // R10: an operation only starts from a host write
  a_r10_rise_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  // R10, R5: busy window is one of the legal durations
  a_r10_legal_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 8'(PROG_CYC) || run_len == 8'(SEC_CYC) ||
                     run_len == 8'(CHIP_CYC) || run_len == 8'(LOCK_CYC)));

  // R6: storage does not move while an operation is in flight
  a_r6_array_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(rd_addr)) |-> $stable(rd_data));

  // R6, R8: the decoder holds no partial sequence during an operation
  a_r6_decoder_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> dec_idle);
endmodule

bind flash_cmd_ctrl flash_cmd_chk #(
  .DW(DW), .IW(IW), .PROG_CYC(PROG_CYC), .SEC_CYC(SEC_CYC),
  .CHIP_CYC(CHIP_CYC), .LOCK_CYC(LOCK_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
  .dec_idle(dec_idle), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int PROG_CYC = 12, SEC_CYC = 16, CHIP_CYC = 20, LOCK_CYC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [10:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [3:0]  lock = '0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYC(PROG_CYC), .SEC_CYC(SEC_CYC),
                   .CHIP_CYC(CHIP_CYC), .LOCK_CYC(LOCK_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .lock(lock), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  typedef struct packed {
    logic        is_erase;
    logic [10:0] a;
    logic [15:0] d;
    logic [4:0]  chk;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 11'd3,  16'h1234, 5'd3,  16'h1234},
    '{1'b0, 11'd3,  16'hFF0F, 5'd3,  16'h1204},
    '{1'b0, 11'd9,  16'hA5A5, 5'd9,  16'hA5A5},
    '{1'b0, 11'd20, 16'h0F0F, 5'd20, 16'h0F0F},
    '{1'b1, 11'd8,  16'h0030, 5'd9,  16'hFFFF},
    '{1'b0, 11'd31, 16'h8001, 5'd31, 16'h8001}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd_prog(input logic [10:0] a, input logic [15:0] d);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(a, d);
  endtask

  task automatic cmd_erase(input logic [10:0] a, input logic [7:0] c);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(a, {8'h00, c});
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] v;
    logic all_ones;

    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after release", busy, 0);

    cmd_erase(11'h555, 8'h10);
    wait_idle(n);
    check("R10 chip erase length", n, CHIP_CYC);
    all_ones = 1'b1;
    for (int i = 0; i < 32; i++) begin
      rd(5'(i), v);
      if (v !== 16'hFFFF) all_ones = 1'b0;
    end
    check("R4 full erase all ones", all_ones, 1);

    for (int k = 0; k < 6; k++) begin
      if (VEC[k].is_erase) cmd_erase(VEC[k].a, VEC[k].d[7:0]);
      else                 cmd_prog(VEC[k].a, VEC[k].d);
      wait_idle(n);
      check(VEC[k].is_erase ? "R10 sector erase length" : "R10 program length",
            n, VEC[k].is_erase ? SEC_CYC : PROG_CYC);
      rd(VEC[k].chk, v);
      check(VEC[k].is_erase ? "R3 sector word erased" : "R2 program AND",
            v, VEC[k].exp);
    end
    rd(5'd3, v);  check("R3 other sector kept", v, 16'h1204);
    rd(5'd20, v); check("R3 other sector kept 2", v, 16'h0F0F);

    lock = 4'b0100;
    cmd_erase(11'd16, 8'h30);
    wait_idle(n);
    check("R5 locked erase length", n, LOCK_CYC);
    rd(5'd20, v); check("R5 locked sector kept", v, 16'h0F0F);

    cmd_erase(11'h555, 8'h10);
    wait_idle(n);
    check("R4 chip erase length", n, CHIP_CYC);
    rd(5'd20, v); check("R4 locked sector kept", v, 16'h0F0F);
    rd(5'd3, v);  check("R4 unlocked erased", v, 16'hFFFF);
    rd(5'd31, v); check("R4 unlocked erased 2", v, 16'hFFFF);
    lock = 4'b0000;

    wr(11'h555, 16'h77AA); wr(11'h2AA, 16'h1255); wr(11'h555, 16'hFFA0); wr(11'd2, 16'h3C3C);
    wait_idle(n);
    rd(5'd2, v); check("R7 upper bits ignored", v, 16'h3C3C);

    cmd_prog(11'd0, 16'h00FF);
    cmd_prog(11'd1, 16'h0000);
    check("R6 still busy", busy, 1);
    wait_idle(n);
    wr(11'd1, 16'h0000);
    check("R6 no late start", busy, 0);
    rd(5'd0, v); check("R6 first program done", v, 16'h00FF);
    rd(5'd1, v); check("R6 ignored program", v, 16'hFFFF);

    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0090);
    wr(11'h555, 16'h00A0); wr(11'd2, 16'h0000);
    check("R8 bad code no op", busy, 0);
    wr(11'h555, 16'h00AA); wr(11'h123, 16'h0055); wr(11'h555, 16'h00A0); wr(11'd2, 16'h0000);
    check("R8 bad address no op", busy, 0);
    rd(5'd2, v); check("R8 array kept", v, 16'h3C3C);

    cmd_prog(11'd10, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 abort clears busy", busy, 0);
    rst_n = 1'b1;
    rd(5'd9, v); check("R9 neighbour kept", v, 16'hFFFF);
    rd(5'd3, v); check("R9 other sector kept", v, 16'hFFFF);
    cmd_prog(11'd11, 16'h5A5A);
    wait_idle(n);
    check("R9 program after abort length", n, PROG_CYC);
    rd(5'd11, v); check("R9 program after abort", v, 16'h5A5A);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule